// File: doc/BRIEF.md
# Data-Strobe Token Serializer

This block turns link-level requests into a serial data/strobe line pair. A requester raises a time-code, flow-control or character request and holds it until the matching acknowledge pulse. At each token boundary the block picks what goes next, builds the bit pattern, puts the running parity bit at its head and shifts it out one bit per bit-rate enable. The data/strobe encoder then drives the two lines. When nothing is requested, idle fill tokens are sent. Everything runs on one clock, and a single-cycle `bit_en` pulse sets the line rate.

On the wire, each token starts with a parity bit and then a flag bit. A control token carries two more bits. A character carries its data bits, least-significant bit first. Idle fill is an escape followed by a flow-control token. A time code is an escape followed by a character that holds the time value. A flow-control request and a character request that are acknowledged together go out back to back. Dropping `tx_en` stops the serializer at once, and the line pair is then brought down to zero in a controlled way.

Top module: `spw_ds_serializer`

## Requirements
- R1: A character goes out as 10 bits in this order: parity, flag 0, then `char_data` bit 0 up to bit 7. A control token goes out as 4 bits: parity, flag 1, then two code bits in order. The codes are escape 1,1; flow-control 0,0; end-of-packet 0,1; error-end 1,0.
- R2: Every token's parity bit makes the XOR of the preceding token's bits after its flag, this parity bit and this token's flag equal to 1. After enable, the preceding bits count as 0.
- R3: At a token boundary with no acceptable request and nothing pending, an idle fill is sent: escape, then flow-control.
- R4: A time code is sent as escape followed by a character carrying `time_val`. A time-code request wins over flow-control and character requests made at the same boundary, and `fct_ack` stays low in the cycle of `time_ack`.
- R5: When flow-control and character requests are both accepted at one boundary, `fct_ack` and `char_ack` pulse in the same cycle. The flow-control token is then followed directly by the character.
- R6: Characters and time codes are accepted only after at least one requested flow-control token since enable. Acks pulse for one cycle and only while `tx_en` is high.
- R7: The lines change only in a cycle after `bit_en`. While running, strobe toggles exactly when the new data bit equals the previous one, so data XOR strobe flips every bit period.
- R8: While `tx_en` is low, each `bit_en` sets strobe to 0 and data to (data AND strobe). The lines therefore reach zero with at most one change per bit period.
- R9: After `tx_en` rises, the first token sent is the escape of an idle fill, followed by its flow-control token, whatever is being requested.
- R10: During reset both lines are 0 and no acknowledge is asserted.
- R11: With `char_eop` high, the character request sends end-of-packet if `char_data[0]` is 0, and error-end if it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| bit_en | input | 1 | One-cycle pulse per bit period |
| time_req | input | 1 | Time-code request, held until acked |
| time_val | input | CHAR_W | Time-code value |
| time_ack | output | 1 | Time-code request consumed |
| fct_req | input | 1 | Flow-control token request |
| fct_ack | output | 1 | Flow-control request consumed |
| char_req | input | 1 | Character or packet-end request |
| char_eop | input | 1 | 1: packet end, selected by char_data[0] |
| char_data | input | CHAR_W | Character value |
| char_ack | output | 1 | Character request consumed |
| ds_d | output | 1 | Data line |
| ds_s | output | 1 | Strobe line |

## Verification
An acknowledge is combinational. It is high during the clock cycle whose closing edge loads the next pattern, so the bench samples it on the falling edge and releases the request after the following rising edge. A loaded token's first bit appears on the lines one `bit_en` edge after the load, and each later bit appears one enable edge after the one before. The bench therefore decodes the lines by watching data XOR strobe change at falling edges, which needs no knowledge of the enable phase. Shutdown levels are checked several bit periods after `tx_en` falls, which is past the two enable edges the gentle descent needs.

// File: rtl/spw_ser_pkg.sv
package spw_ser_pkg;

   // Two code bits after the flag, index 0 is sent first.
   localparam logic [1:0] CODE_ESC = 2'b11;
   localparam logic [1:0] CODE_FCT = 2'b00;
   localparam logic [1:0] CODE_EOP = 2'b10;
   localparam logic [1:0] CODE_EEP = 2'b01;

   localparam int CTRL_BITS = 4;

   // Second half of a split token waiting for the next boundary.
   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_FCT  = 2'd1,
      PEND_CHAR = 2'd2
   } pend_e;

endpackage

// File: rtl/spw_tok_sel.sv
module spw_tok_sel
   import spw_ser_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              load,
   input  logic              time_req,
   input  logic [CHAR_W-1:0] time_val,
   input  logic              fct_req,
   input  logic              char_req,
   input  logic              char_eop,
   input  logic [CHAR_W-1:0] char_data,
   output logic              time_ack,
   output logic              fct_ack,
   output logic              char_ack,
   output logic              nxt_ctrl,
   output logic [CHAR_W-1:0] nxt_body
);

   pend_e             pend_q, pend_d;
   logic              first_q, first_d;
   logic              sent_q, sent_d;
   logic              peop_q, peop_d;
   logic [CHAR_W-1:0] pdat_q, pdat_d;

   logic              use_char, ch_eop;
   logic [CHAR_W-1:0] ch_data;
   logic [1:0]        code;
   logic              t_sel, f_sel, c_sel;

   always_comb begin
      pend_d   = pend_q;
      first_d  = first_q;
      sent_d   = sent_q;
      peop_d   = peop_q;
      pdat_d   = pdat_q;
      code     = CODE_ESC;
      use_char = 1'b0;
      ch_eop   = 1'b0;
      ch_data  = '0;
      t_sel    = 1'b0;
      f_sel    = 1'b0;
      c_sel    = 1'b0;
      if (first_q) begin
         first_d = 1'b0;
         pend_d  = PEND_FCT;
      end else if (pend_q == PEND_FCT) begin
         code   = CODE_FCT;
         pend_d = PEND_NONE;
      end else if (pend_q == PEND_CHAR) begin
         use_char = 1'b1;
         ch_eop   = peop_q;
         ch_data  = pdat_q;
         pend_d   = PEND_NONE;
      end else if (time_req && sent_q) begin
         t_sel  = 1'b1;
         pend_d = PEND_CHAR;
         peop_d = 1'b0;
         pdat_d = time_val;
      end else if (fct_req) begin
         f_sel  = 1'b1;
         code   = CODE_FCT;
         sent_d = 1'b1;
         if (char_req && sent_q) begin
            c_sel  = 1'b1;
            pend_d = PEND_CHAR;
            peop_d = char_eop;
            pdat_d = char_data;
         end
      end else if (char_req && sent_q) begin
         c_sel    = 1'b1;
         use_char = 1'b1;
         ch_eop   = char_eop;
         ch_data  = char_data;
      end else begin
         pend_d = PEND_FCT;
      end

      if (use_char) begin
         nxt_ctrl = ch_eop;
         if (ch_eop) begin
            nxt_body = {{(CHAR_W-2){1'b0}}, (ch_data[0] ? CODE_EEP : CODE_EOP)};
         end else begin
            nxt_body = ch_data;
         end
      end else begin
         nxt_ctrl = 1'b1;
         nxt_body = {{(CHAR_W-2){1'b0}}, code};
      end
   end

   assign time_ack = load & t_sel;
   assign fct_ack  = load & f_sel;
   assign char_ack = load & c_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= PEND_NONE;
         first_q <= 1'b1;
         sent_q  <= 1'b0;
         peop_q  <= 1'b0;
         pdat_q  <= '0;
      end else if (!tx_en) begin
         pend_q  <= PEND_NONE;
         first_q <= 1'b1;
         sent_q  <= 1'b0;
      end else if (load) begin
         pend_q  <= pend_d;
         first_q <= first_d;
         sent_q  <= sent_d;
         peop_q  <= peop_d;
         pdat_q  <= pdat_d;
      end
   end

endmodule

// File: rtl/spw_bit_shifter.sv
module spw_bit_shifter
   import spw_ser_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter bit ONEHOT_CNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              bit_en,
   input  logic              nxt_ctrl,
   input  logic [CHAR_W-1:0] nxt_body,
   output logic              load,
   output logic              run,
   output logic              bit_out
);

   localparam int SH_W = CHAR_W + 2;
   localparam int CW   = $clog2(SH_W);

   logic [SH_W-1:0] sh_q;
   logic            run_q;
   logic            dpar_q;
   logic            last;

   assign load    = tx_en & bit_en & last;
   assign run     = run_q;
   assign bit_out = sh_q[0];

   generate
      if (ONEHOT_CNT) begin : g_onehot
         logic [SH_W-1:0] cnt_q;
         assign last = cnt_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= SH_W'(1);
            end else if (!tx_en) begin
               cnt_q <= SH_W'(1);
            end else if (bit_en) begin
               if (cnt_q[0]) begin
                  cnt_q <= nxt_ctrl ? (SH_W'(1) << (CTRL_BITS-1)) : (SH_W'(1) << (SH_W-1));
               end else begin
                  cnt_q <= cnt_q >> 1;
               end
            end
         end
      end else begin : g_binary
         logic [CW-1:0] cnt_q;
         assign last = (cnt_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!tx_en) begin
               cnt_q <= '0;
            end else if (bit_en) begin
               if (cnt_q == '0) begin
                  cnt_q <= nxt_ctrl ? CW'(CTRL_BITS-1) : CW'(SH_W-1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         run_q  <= 1'b0;
         dpar_q <= 1'b0;
      end else if (!tx_en) begin
         run_q  <= 1'b0;
         dpar_q <= 1'b0;
      end else if (bit_en) begin
         if (last) begin
            sh_q   <= {nxt_body, nxt_ctrl, ~(dpar_q ^ nxt_ctrl)};
            dpar_q <= ^nxt_body;
            run_q  <= 1'b1;
         end else begin
            sh_q <= sh_q >> 1;
         end
      end
   end

endmodule

// File: rtl/spw_ds_enc.sv
module spw_ds_enc (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic run,
   input  logic bit_in,
   output logic ds_d,
   output logic ds_s
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ds_d <= 1'b0;
         ds_s <= 1'b0;
      end else if (bit_en) begin
         if (run) begin
            ds_d <= bit_in;
            ds_s <= ds_s ^ ~(bit_in ^ ds_d);
         end else begin
            ds_d <= ds_d & ds_s;
            ds_s <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spw_ds_serializer.sv
module spw_ds_serializer #(
   parameter int CHAR_W     = 8,
   parameter bit ONEHOT_CNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              bit_en,
   input  logic              time_req,
   input  logic [CHAR_W-1:0] time_val,
   output logic              time_ack,
   input  logic              fct_req,
   output logic              fct_ack,
   input  logic              char_req,
   input  logic              char_eop,
   input  logic [CHAR_W-1:0] char_data,
   output logic              char_ack,
   output logic              ds_d,
   output logic              ds_s
);

   generate
      if (CHAR_W < 2) begin : g_bad_width
         $error("spw_ds_serializer: CHAR_W must be at least 2");
      end
   endgenerate

   logic              load;
   logic              sh_run;
   logic              sh_bit;
   logic              enc_run;
   logic              nxt_ctrl;
   logic [CHAR_W-1:0] nxt_body;

   spw_tok_sel #(.CHAR_W(CHAR_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .load      (load),
      .time_req  (time_req),
      .time_val  (time_val),
      .fct_req   (fct_req),
      .char_req  (char_req),
      .char_eop  (char_eop),
      .char_data (char_data),
      .time_ack  (time_ack),
      .fct_ack   (fct_ack),
      .char_ack  (char_ack),
      .nxt_ctrl  (nxt_ctrl),
      .nxt_body  (nxt_body)
   );

   spw_bit_shifter #(.CHAR_W(CHAR_W), .ONEHOT_CNT(ONEHOT_CNT)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .bit_en   (bit_en),
      .nxt_ctrl (nxt_ctrl),
      .nxt_body (nxt_body),
      .load     (load),
      .run      (sh_run),
      .bit_out  (sh_bit)
   );

   assign enc_run = sh_run & tx_en;

   spw_ds_enc u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .run    (enc_run),
      .bit_in (sh_bit),
      .ds_d   (ds_d),
      .ds_s   (ds_s)
   );

endmodule

// File: rtl/spw_ds_chk.sv
module spw_ds_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic bit_en,
   input logic run,
   input logic time_ack,
   input logic fct_ack,
   input logic char_ack,
   input logic ds_d,
   input logic ds_s
);

   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q <= 1'b0;
      else if (!tx_en)  seen_q <= 1'b0;
      else if (fct_ack) seen_q <= 1'b1;
   end

   a_r7_ds_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && run) |=> ((ds_d ^ ds_s) != $past(ds_d ^ ds_s)));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(ds_d) && $stable(ds_s)));

   a_r8_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !tx_en) |=> (!ds_s && (ds_d == ($past(ds_d) && $past(ds_s)))));

   a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (time_ack || char_ack) |-> seen_q);

   a_r6_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (time_ack || fct_ack || char_ack) |-> tx_en);

   a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
      time_ack |-> (!fct_ack && !char_ack));

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r10_quiet: assert (!ds_d && !ds_s && !time_ack && !fct_ack && !char_ack);
      end
   end

endmodule

bind spw_ds_serializer spw_ds_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_en    (tx_en),
   .bit_en   (bit_en),
   .run      (enc_run),
   .time_ack (time_ack),
   .fct_ack  (fct_ack),
   .char_ack (char_ack),
   .ds_d     (ds_d),
   .ds_s     (ds_s)
);

// File: tb/sim_spw_ds_serializer.sv
`timescale 1ns/1ps
module sim_spw_ds_serializer;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, tx_en, bit_en;
   logic       time_req, fct_req, char_req, char_eop;
   logic [7:0] time_val, char_data;
   logic       time_ack, fct_ack, char_ack, ds_d, ds_s;

   spw_ds_serializer u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_en(bit_en),
      .time_req(time_req), .time_val(time_val), .time_ack(time_ack),
      .fct_req(fct_req), .fct_ack(fct_ack),
      .char_req(char_req), .char_eop(char_eop), .char_data(char_data),
      .char_ack(char_ack), .ds_d(ds_d), .ds_s(ds_s)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bit enable: one cycle high out of three
   initial begin
      bit_en = 1'b0;
      forever begin
         repeat (2) @(posedge clk);
         #1 bit_en = 1'b1;
         @(posedge clk);
         #1 bit_en = 1'b0;
      end
   end

   // Line decoder: a change of data XOR strobe marks a new bit
   bit   dec_on = 1'b0;
   logic last_x = 1'b0;
   logic prevp = 1'b0;
   bit   esc_p = 1'b0;
   logic [9:0] tb = '0;
   int nb = 0, par_bad = 0, esc_bad = 0, null_n = 0, raw_n = 0;
   int raw0 = -1, raw1 = -1, last_comp = -1, log_n = 0, exp_n = 0;
   bit ff_ok = 1'b0;
   int log_q [0:63];
   int exp_q [0:63];

   task automatic emit(input int c);
      if (c == 255 && last_comp == 256) ff_ok = 1'b1;
      last_comp = c;
      if (c != 1024 && log_n < 64) begin
         log_q[log_n] = c;
         log_n++;
      end
   endtask

   always @(negedge clk) begin
      if (dec_on && ((ds_d ^ ds_s) != last_x)) begin
         int code;
         last_x = ds_d ^ ds_s;
         tb[nb] = ds_d;
         nb++;
         if (nb >= 2 && nb == (tb[1] ? 4 : 10)) begin
            if ((tb[0] ^ prevp ^ tb[1]) != 1'b1) par_bad++;
            if (tb[1]) begin
               prevp = tb[2] ^ tb[3];
               code  = 256 + int'({tb[2], tb[3]});
            end else begin
               prevp = ^tb[9:2];
               code  = int'(tb[9:2]);
            end
            if (raw_n == 0) raw0 = code;
            if (raw_n == 1) raw1 = code;
            raw_n++;
            if (code == 259) begin
               if (esc_p) esc_bad++;
               esc_p = 1'b1;
            end else if (esc_p) begin
               esc_p = 1'b0;
               if (code == 256)     emit(1024);
               else if (code < 256) emit(512 + code);
               else                 esc_bad++;
               if (code == 256) null_n++;
            end else begin
               emit(code);
            end
            nb = 0;
         end
      end
   end

   bit cack_seen = 1'b0;
   always @(negedge clk) if (char_ack) cack_seen = 1'b1;

   // kind: 0 FCT, 1 char, 2 EOP, 3 EEP, 4 time code, 5 FCT+char
   localparam logic [10:0] STIM [8] = '{
      {3'd0, 8'h00}, {3'd1, 8'hA5}, {3'd1, 8'h00}, {3'd2, 8'h00},
      {3'd3, 8'h00}, {3'd4, 8'h3C}, {3'd5, 8'hFF}, {3'd1, 8'h5A}
   };

   task automatic push_exp(input int c);
      exp_q[exp_n] = c;
      exp_n++;
   endtask

   task automatic send(input int kind, input logic [7:0] v);
      bit got = 1'b0, af = 1'b0, ac = 1'b0, at = 1'b0;
      bit ef, ec, et;
      string tag;
      @(posedge clk);
      #1;
      case (kind)
         0: fct_req = 1'b1;
         1: begin char_req = 1'b1; char_eop = 1'b0; char_data = v; end
         2: begin char_req = 1'b1; char_eop = 1'b1; char_data = 8'h00; end
         3: begin char_req = 1'b1; char_eop = 1'b1; char_data = 8'h01; end
         4: begin time_req = 1'b1; time_val = v; end
         default: begin fct_req = 1'b1; char_req = 1'b1; char_eop = 1'b0; char_data = v; end
      endcase
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (fct_ack || char_ack || time_ack) begin
            got = 1'b1; af = fct_ack; ac = char_ack; at = time_ack;
            break;
         end
      end
      @(posedge clk);
      #1;
      fct_req = 1'b0; char_req = 1'b0; time_req = 1'b0; char_eop = 1'b0;
      ef = (kind == 0 || kind == 5);
      ec = (kind >= 1 && kind <= 3) || kind == 5;
      et = (kind == 4);
      tag = (kind == 0) ? "R6 fct ack" : (kind == 1) ? "R1 char ack" :
            (kind <= 3) ? "R11 end ack" : (kind == 4) ? "R4 time ack" : "R5 joint ack";
      check(got && af == ef && ac == ec && at == et, tag,
            int'({got, af, ac, at}), int'({1'b1, ef, ec, et}));
      case (kind)
         0: push_exp(256);
         1: push_exp(int'(v));
         2: push_exp(257);
         3: push_exp(258);
         4: push_exp(512 + int'(v));
         default: begin push_exp(256); push_exp(int'(v)); end
      endcase
   endtask

   initial begin
      #300000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tx_en = 1'b0;
      time_req = 1'b0; fct_req = 1'b0; char_req = 1'b0; char_eop = 1'b0;
      time_val = '0; char_data = '0;
      repeat (4) @(negedge clk);
      // R10: quiet during reset
      check(!ds_d && !ds_s && !fct_ack && !char_ack && !time_ack, "R10 reset",
            int'({ds_d, ds_s, fct_ack, char_ack, time_ack}), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R9/R6/R3: enable with a character request but no FCT yet
      @(posedge clk); #1;
      dec_on = 1'b1;
      tx_en = 1'b1; char_req = 1'b1; char_data = 8'h77;
      repeat (150) @(negedge clk);
      check(!cack_seen, "R6 char before fct", int'(cack_seen), 0);
      check(log_n == 0, "R3 only fill", log_n, 0);
      check(null_n > 0, "R3 fill present", null_n, 1);
      check(raw0 == 259, "R9 first escape", raw0, 259);
      check(raw1 == 256, "R9 then fct", raw1, 256);
      @(posedge clk); #1 char_req = 1'b0;

      // Table of request patterns
      for (int i = 0; i < 8; i++) begin
         send(int'(STIM[i][10:8]), STIM[i][7:0]);
         repeat (60) @(negedge clk);
      end

      // R4: time code beats flow-control at the same boundary
      @(posedge clk); #1;
      time_req = 1'b1; time_val = 8'hC3; fct_req = 1'b1;
      begin
         bit t_first = 1'b0, f_later = 1'b0;
         for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (time_ack || fct_ack) begin t_first = time_ack && !fct_ack; break; end
         end
         @(posedge clk); #1 time_req = 1'b0;
         for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (fct_ack) begin f_later = 1'b1; break; end
         end
         @(posedge clk); #1 fct_req = 1'b0;
         check(t_first, "R4 priority", int'(t_first), 1);
         check(f_later, "R4 fct after", int'(f_later), 1);
         push_exp(512 + 8'hC3);
         push_exp(256);
      end
      repeat (100) @(negedge clk);

      // R8: shutdown brings lines to zero
      @(posedge clk); #1;
      dec_on = 1'b0; tx_en = 1'b0;
      repeat (20) @(negedge clk);
      check(!ds_d && !ds_s, "R8 lines zero", int'({ds_d, ds_s}), 0);

      // R9: re-enable restarts with an idle fill and fresh parity
      @(posedge clk); #1;
      last_x = 1'b0; nb = 0; prevp = 1'b0; esc_p = 1'b0; raw_n = 0; raw0 = -1; raw1 = -1;
      dec_on = 1'b1; tx_en = 1'b1;
      send(0, 8'h00);
      repeat (100) @(negedge clk);
      check(raw0 == 259 && raw1 == 256, "R9 restart fill", raw0, 259);

      // R1/R11/R4/R5: decoded stream matches request order
      check(log_n == exp_n, "R1 token count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
         check(log_q[i] == exp_q[i], "R1 token value", log_q[i], exp_q[i]);
      check(ff_ok, "R5 back to back", int'(ff_ok), 1);
      check(par_bad == 0, "R2 parity", par_bad, 0);
      check(esc_bad == 0, "R3 escape pairing", esc_bad, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule